// File: doc/BRIEF.md
# Polled Receive Byte Buffer

This block sits between a serial byte receiver and a processor bus. The receiver hands over each byte with a one-cycle strobe, and the block keeps up to four bytes in first-in, first-out order. Software reads from the block through a single address. Each read-select pulse removes the oldest byte and returns a 32-bit word. That word carries the byte, a flag telling whether the byte is real, and a flag telling whether any byte was lost since the previous read.

A processor only needs to poll that one location. It should act on the data when the valid flag is set and log a loss when the overflow flag is set. There is no separate status register. The returned word appears in the clock cycle after the select pulse and holds there until the next read.

Top module: `rwf_top`

## Requirements
- R1: After reset (asynchronous, active-low `rst_n`), the read word is all zeros, the buffer is empty and no overflow is pending. A read issued right after reset returns all zeros.
- R2: Up to four bytes are stored, and successive reads return them in the order they were pushed.
- R3: A read word is registered on the clock edge that samples `pop_i` high, so it is visible in the following cycle. In cycles without a pop, `rd_word_o` keeps its value.
- R4: A read from a non-empty buffer returns the oldest byte in bits 7:0 and sets bit 30 (valid).
- R5: A read from an empty buffer returns 0 in bits 7:0 and 0 in bit 30, and no entry is removed.
- R6: A push while the buffer holds four bytes and no pop occurs in that cycle is discarded. The four stored bytes stay unchanged.
- R7: Bit 31 (overflow) of a read word is 1 when at least one push was discarded since the previous read. The read that reports it clears the flag, so the next read shows 0 unless a new loss occurs.
- R8: Bits 29:8 of the read word are always 0.
- R9: A push and a pop in the same cycle on a non-empty buffer (including a full one) both take effect, and the fill level stays the same.
- R10: A push and a pop in the same cycle on an empty buffer report no data (bit 30 = 0), and the pushed byte is stored for the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| push_i | input | 1 | One-cycle strobe from the byte receiver |
| push_data_i | input | 8 | Byte delivered with `push_i` |
| pop_i | input | 1 | One-cycle read-select pulse from the bus decoder |
| rd_word_o | output | 32 | Read word: byte in 7:0, valid in 30, overflow in 31 |

## Verification
The embedded assertions check the following properties on every cycle: the fill level stays within four, a dropped push leaves the buffer full, and an empty read leaves it empty. They also check that a simultaneous push and pop keeps the level, that the overflow flag sets on a loss and clears on a read, that the word holds between reads, and that the padding bits stay zero. Only the bench scenarios can show that bytes come back in arrival order and that a dropped byte never reappears. The same holds for the exact byte returned after mixed push and pop traffic, and for the overflow bit landing on exactly one read. A reference queue model in the bench, driven by directed corner cases and seeded random traffic, covers these.

// File: rtl/rwf_pkg.sv
package rwf_pkg;
  localparam int BYTE_W  = 8;
  localparam int WORD_W  = 32;
  localparam int PAD_W   = WORD_W - BYTE_W - 2;

  typedef struct packed {
    logic             ovf;    // bit 31
    logic             valid;  // bit 30
    logic [PAD_W-1:0] pad;    // bits 29:8
    logic [BYTE_W-1:0] data;  // bits 7:0
  } rd_word_t;

  function automatic rd_word_t pack_word(input logic [BYTE_W-1:0] data,
                                         input logic valid,
                                         input logic ovf);
    rd_word_t w;
    w.ovf   = ovf;
    w.valid = valid;
    w.pad   = '0;
    w.data  = valid ? data : '0;
    return w;
  endfunction
endpackage

// File: rtl/rwf_store.sv
module rwf_store #(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] head_o,
  output logic              empty_o,
  output logic              full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              pop_ok, push_ok;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == FULL_CNT);
  assign head_o  = mem_q[rd_ptr_q];
  assign pop_ok  = pop_i && !empty_o;
  assign push_ok = push_i && (!full_o || pop_ok);

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (push_ok) wr_ptr_d = (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
    if (pop_ok)  rd_ptr_d = (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
    case ({push_ok, pop_ok})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    logic wr_en;
    assign wr_en = push_ok && (wr_ptr_q == PTR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     mem_q[g] <= '0;
      else if (wr_en) mem_q[g] <= data_i;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT); // R2
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && push_i && !pop_i) |=> (full_o && $stable(wr_ptr_q))); // R6
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_o && pop_i && !push_i) |=> (empty_o && $stable(rd_ptr_q))); // R5
  AST_PUSHPOP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_o && push_i && pop_i) |=> $stable(cnt_q)); // R9
  AST_EMPTY_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_o && push_i && pop_i) |=> (cnt_q == CNT_W'(1))); // R10
endmodule

// File: rtl/rwf_ovf.sv
module rwf_ovf (
  input  logic clk,
  input  logic rst_n,
  input  logic push_i,
  input  logic pop_i,
  input  logic full_i,
  output logic ovf_o
);
  logic ovf_q, ovf_d;
  logic lost;

  assign lost  = push_i && full_i && !pop_i;
  assign ovf_o = ovf_q;

  always_comb begin
    ovf_d = ovf_q;
    if (pop_i)     ovf_d = 1'b0;
    else if (lost) ovf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= 1'b0;
    else        ovf_q <= ovf_d;
  end

  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full_i && !pop_i) |=> ovf_q); // R7
  AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |=> !ovf_q); // R7
endmodule

// File: rtl/rwf_word.sv
module rwf_word
  import rwf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pop_i,
  input  logic              valid_i,
  input  logic              ovf_i,
  input  logic [BYTE_W-1:0] data_i,
  output rd_word_t          word_o
);
  rd_word_t word_q, word_d;
  logic     load_en;

  assign load_en = pop_i;
  assign word_o  = word_q;

  always_comb begin
    word_d = word_q;
    if (load_en) word_d = pack_word(data_i, valid_i, ovf_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pop_i |=> $stable(word_q)); // R3
  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !valid_i) |=> (word_q.data == '0 && !word_q.valid)); // R5
  AST_FLAG_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |=> (word_q.valid == $past(valid_i) && word_q.ovf == $past(ovf_i))); // R4
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    word_q.pad == '0); // R8
endmodule

// File: rtl/rwf_top.sv
module rwf_top
  import rwf_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [BYTE_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [WORD_W-1:0] rd_word_o
);
  logic [BYTE_W-1:0] head;
  logic              empty, full, ovf;
  rd_word_t          word;

  rwf_store #(.DEPTH(DEPTH), .DATA_W(BYTE_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (push_i),
    .data_i  (push_data_i),
    .pop_i   (pop_i),
    .head_o  (head),
    .empty_o (empty),
    .full_o  (full)
  );

  rwf_ovf u_ovf (
    .clk    (clk),
    .rst_n  (rst_n),
    .push_i (push_i),
    .pop_i  (pop_i),
    .full_i (full),
    .ovf_o  (ovf)
  );

  rwf_word u_word (
    .clk     (clk),
    .rst_n   (rst_n),
    .pop_i   (pop_i),
    .valid_i (!empty),
    .ovf_i   (ovf),
    .data_i  (head),
    .word_o  (word)
  );

  assign rd_word_o = word;

  AST_RESET_WORD: assert property (@(posedge clk) !rst_n |-> rd_word_o == '0); // R1
endmodule

// File: tb/rwf_top_bench.sv
`timescale 1ns/1ps
module rwf_top_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        push;
  logic [7:0]  pdata;
  logic        pop;
  logic [31:0] rd_word;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0]  mq [4];
  int          mcnt;
  logic        movf;
  logic [31:0] mword;

  always #5 clk = ~clk;

  rwf_top u_rwf_top (
    .clk(clk), .rst_n(rst_n), .push_i(push), .push_data_i(pdata),
    .pop_i(pop), .rd_word_o(rd_word)
  );

  function automatic logic [31:0] model_word(input int cnt, input logic [7:0] head,
                                             input logic ovf);
    return {ovf, (cnt != 0), 22'b0, (cnt != 0) ? head : 8'h00};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    mcnt = 0; movf = 1'b0; mword = '0;
    for (int i = 0; i < 4; i++) mq[i] = 8'h00;
  endtask

  task automatic step(input logic ps, input logic [7:0] d, input logic pp, input string tag);
    bit pop_ok, push_ok;
    @(negedge clk);
    push = ps; pdata = d; pop = pp;
    if (pp) mword = model_word(mcnt, mq[0], movf);
    pop_ok  = pp && (mcnt > 0);
    push_ok = ps && ((mcnt < 4) || pop_ok);
    movf = pp ? 1'b0 : (movf | (ps && mcnt == 4));
    if (pop_ok) begin
      for (int i = 0; i < 3; i++) mq[i] = mq[i+1];
      mcnt--;
    end
    if (push_ok) begin
      mq[mcnt] = d;
      mcnt++;
    end
    @(posedge clk);
    #1;
    push = 1'b0; pop = 1'b0;
    check(tag, rd_word, mword);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    push = 1'b0; pop = 1'b0; pdata = 8'h00;
    model_reset();
    @(negedge clk);
    check("R1 word zero in reset", rd_word, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; push = 1'b0; pop = 1'b0; pdata = 8'h00;
    model_reset();
    do_reset();
    // R1: first read after reset returns zero
    step(1'b0, 8'h00, 1'b1, "R1");
    // R2: ordering of three bytes
    step(1'b1, 8'hA1, 1'b0, "R3");
    step(1'b1, 8'hB2, 1'b0, "R3");
    step(1'b1, 8'hC3, 1'b0, "R3");
    step(1'b0, 8'h00, 1'b1, "R2");
    step(1'b0, 8'h00, 1'b1, "R2");
    step(1'b0, 8'h00, 1'b1, "R4");
    // R5: empty read
    step(1'b0, 8'h00, 1'b1, "R5");
    check("R5 valid bit clear", {31'b0, rd_word[30]}, 32'h0);
    // R6 / R7: fill, overflow twice, drain
    for (int i = 0; i < 4; i++) step(1'b1, 8'h10 + 8'(i), 1'b0, "R3");
    step(1'b1, 8'hEE, 1'b0, "R6");
    step(1'b1, 8'hEF, 1'b0, "R6");
    step(1'b0, 8'h00, 1'b1, "R7");
    check("R7 overflow bit set", {31'b0, rd_word[31]}, 32'h1);
    step(1'b0, 8'h00, 1'b1, "R7");
    check("R7 overflow bit cleared", {31'b0, rd_word[31]}, 32'h0);
    step(1'b0, 8'h00, 1'b1, "R6");
    step(1'b0, 8'h00, 1'b1, "R6");
    step(1'b0, 8'h00, 1'b1, "R5");
    // R3: hold between reads
    step(1'b0, 8'h00, 1'b0, "R3");
    step(1'b0, 8'h00, 1'b0, "R3");
    // R10: push + pop on empty
    step(1'b1, 8'h5A, 1'b1, "R10");
    step(1'b0, 8'h00, 1'b1, "R10");
    // R9: push + pop on non-empty and on full
    step(1'b1, 8'h61, 1'b0, "R3");
    step(1'b1, 8'h62, 1'b1, "R9");
    step(1'b0, 8'h00, 1'b1, "R9");
    for (int i = 0; i < 4; i++) step(1'b1, 8'h70 + 8'(i), 1'b0, "R3");
    step(1'b1, 8'h7F, 1'b1, "R9");
    check("R9 no overflow pending", {31'b0, rd_word[31]}, 32'h0);
    for (int i = 0; i < 5; i++) step(1'b0, 8'h00, 1'b1, "R9");
    // R1: reset in the middle of traffic
    step(1'b1, 8'h99, 1'b0, "R3");
    do_reset();
    step(1'b0, 8'h00, 1'b1, "R1");
    // random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0] | r[1], r[15:8], r[2] & r[3], "R4");
      check("R8 padding zero", {10'b0, rd_word[29:8]}, 32'h0);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule